// File: doc/BRIEF.md
# Masked BAR Window Decoder

The block holds the configuration of four address windows and decodes a system address against them. Two windows serve memory-mapped I/O and take their size from a programmable mask. The third covers a fixed-size register space. The fourth covers a fixed-size interrupt space. A single enable register switches each window on or off.

Software writes all of this state through a 64-bit register port, one full word per access. Each register keeps only the bits that its window's alignment allows. The decoder is combinational. For any incoming address it returns a one-hot hit vector and the byte offset into the winning window.

When software rewrites the base or mask of a window that is currently enabled, the block still accepts the write. It also raises a one-cycle error pulse.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every register reads zero, every window is disabled, `hit_vec` is zero and `rewrite_err` is low.
- R2: The register index is `reg_addr[7:3]`, so the three low address bits are ignored. Index 0 is the MMIO0 base, 1 the MMIO0 mask, 2 the MMIO1 base, 3 the MMIO1 mask, 4 the register-window base, 5 the interrupt-window base and 6 the enable register. A write to any other index changes nothing, and a read of any other index returns zero.
- R3: A write to the enable register keeps only bits 63:60 and clears the rest. Bit 63 enables MMIO0, bit 62 MMIO1, bit 61 the register window and bit 60 the interrupt window.
- R4: Writes to the two MMIO base registers and the two MMIO mask registers keep bits 63:24 and clear bits 23:0.
- R5: A write to the register-window base keeps bits 63:22. A write to the interrupt-window base keeps bits 63:36.
- R6: The start address of a window is its stored base shifted right by 8. An MMIO window covers [start, start + ((~mask) >> 8) + 1).
- R7: The register window covers REG_COUNT × 8 bytes and the interrupt window covers INT_COUNT × 65536 bytes. The defaults are 8192 registers, giving 64 KiB, and 16 interrupts, giving 1 MiB.
- R8: A disabled window never hits, whatever its base holds.
- R9: `hit_vec` is one-hot or zero. Bit 0 is MMIO0, bit 1 MMIO1, bit 2 the register window and bit 3 the interrupt window. When enabled windows overlap, the priority is MMIO0 > MMIO1 > register window > interrupt window.
- R10: `hit_off` equals the address minus the start of the winning window, and it is zero when no window hits.
- R11: A write to the base or mask of an enabled window takes effect and pulses `rewrite_err` high for the one cycle after the accepting clock edge. The same write to a disabled window leaves `rewrite_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the addressed register (combinational) |
| rewrite_err | output | 1 | Pulse: an enabled window's base or mask was rewritten |
| lk_addr | input | 56 | System address to decode |
| hit_vec | output | 4 | One-hot winning window |
| hit_off | output | 56 | Offset of `lk_addr` inside the winning window |

## Verification
A corrupted base or enable bit shows up at `hit_vec` and `hit_off` in the same cycle as the lookup. It appears as a hit, a miss or an offset error at the edge of the affected window, so the bench probes the first and last byte of every window as well as the byte just past the end. A wrong truncation mask is visible at `reg_rdata` as soon as the register is read back after the write. A mistake in the enable-dependent error logic appears on `rewrite_err` exactly one cycle after the offending write. A broken priority order only shows when two enabled windows overlap, so the bench stacks MMIO1 on top of MMIO0 and then removes MMIO0.

// File: rtl/bar_win_pkg.sv
package bar_win_pkg;
   localparam int NUM_WIN = 4;
   // window numbering, also hit_vec bit position
   localparam int W_MMIO0 = 0;
   localparam int W_MMIO1 = 1;
   localparam int W_REGS  = 2;
   localparam int W_INTR  = 3;
   // register indices (byte address >> 3)
   localparam logic [4:0] IX_M0_BASE = 5'd0;
   localparam logic [4:0] IX_M0_MASK = 5'd1;
   localparam logic [4:0] IX_M1_BASE = 5'd2;
   localparam logic [4:0] IX_M1_MASK = 5'd3;
   localparam logic [4:0] IX_RG_BASE = 5'd4;
   localparam logic [4:0] IX_IN_BASE = 5'd5;
   localparam logic [4:0] IX_ENABLE  = 5'd6;
   // bits retained on write
   localparam logic [63:0] KEEP_MMIO = 64'hFFFF_FFFF_FF00_0000;
   localparam logic [63:0] KEEP_RGWN = 64'hFFFF_FFFF_FFC0_0000;
   localparam logic [63:0] KEEP_INWN = 64'hFFFF_FFF0_0000_0000;
   localparam int BASE_SHIFT = 8;
endpackage

// File: rtl/bar_cfg_regs.sv
module bar_cfg_regs
   import bar_win_pkg::*;
#(
   parameter int REG_AW = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_we,
   input  logic [REG_AW-1:0]         reg_addr,
   input  logic [63:0]               reg_wdata,
   output logic [63:0]               reg_rdata,
   output logic                      rewrite_err,
   output logic [NUM_WIN-1:0][63:0]  base_q,
   output logic [1:0][63:0]          mask_q,
   output logic [NUM_WIN-1:0]        win_en
);
   localparam int IDX_W = REG_AW - 3;

   logic [IDX_W-1:0] idx;
   logic [3:0]       en_raw;
   logic [2:0]       unused_low;
   logic             err_q;

   assign idx        = reg_addr[REG_AW-1:3];
   assign unused_low = reg_addr[2:0];

   // en_raw[3] is register bit 63 (MMIO0); win_en is indexed by window
   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_en_map
         assign win_en[w] = en_raw[NUM_WIN-1-w];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         en_raw <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (reg_we) begin
            case (IDX_W'(idx))
               IDX_W'(IX_M0_BASE): begin
                  base_q[W_MMIO0] <= reg_wdata & KEEP_MMIO;
                  err_q           <= win_en[W_MMIO0];
               end
               IDX_W'(IX_M0_MASK): begin
                  mask_q[0] <= reg_wdata & KEEP_MMIO;
                  err_q     <= win_en[W_MMIO0];
               end
               IDX_W'(IX_M1_BASE): begin
                  base_q[W_MMIO1] <= reg_wdata & KEEP_MMIO;
                  err_q           <= win_en[W_MMIO1];
               end
               IDX_W'(IX_M1_MASK): begin
                  mask_q[1] <= reg_wdata & KEEP_MMIO;
                  err_q     <= win_en[W_MMIO1];
               end
               IDX_W'(IX_RG_BASE): begin
                  base_q[W_REGS] <= reg_wdata & KEEP_RGWN;
                  err_q          <= win_en[W_REGS];
               end
               IDX_W'(IX_IN_BASE): begin
                  base_q[W_INTR] <= reg_wdata & KEEP_INWN;
                  err_q          <= win_en[W_INTR];
               end
               IDX_W'(IX_ENABLE): en_raw <= reg_wdata[63:60];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (IDX_W'(idx))
         IDX_W'(IX_M0_BASE): reg_rdata = base_q[W_MMIO0];
         IDX_W'(IX_M0_MASK): reg_rdata = mask_q[0];
         IDX_W'(IX_M1_BASE): reg_rdata = base_q[W_MMIO1];
         IDX_W'(IX_M1_MASK): reg_rdata = mask_q[1];
         IDX_W'(IX_RG_BASE): reg_rdata = base_q[W_REGS];
         IDX_W'(IX_IN_BASE): reg_rdata = base_q[W_INTR];
         IDX_W'(IX_ENABLE):  reg_rdata = {en_raw, 60'd0};
         default:            reg_rdata = 64'd0;
      endcase
   end

   assign rewrite_err = err_q;
endmodule

// File: rtl/bar_win_match.sv
module bar_win_match #(
   parameter int ADDR_W = 56
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] start,
   input  logic [ADDR_W:0]   size,
   output logic              hit,
   output logic [ADDR_W-1:0] off
);
   logic [ADDR_W:0] diff;

   assign diff = {1'b0, addr} - {1'b0, start};
   // diff[ADDR_W] set means addr < start
   assign hit  = en && !diff[ADDR_W] && (diff < size);
   assign off  = diff[ADDR_W-1:0];
endmodule

// File: rtl/bar_prio_sel.sv
module bar_prio_sel #(
   parameter int N      = 4,
   parameter int ADDR_W = 56
) (
   input  logic [N-1:0]             hit_in,
   input  logic [N-1:0][ADDR_W-1:0] off_in,
   output logic [N-1:0]             hit_out,
   output logic [ADDR_W-1:0]        off_out
);
   // lowest index wins: scan from the top so lower indices overwrite
   always_comb begin
      hit_out = '0;
      off_out = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_in[i]) begin
            hit_out    = '0;
            hit_out[i] = 1'b1;
            off_out    = off_in[i];
         end
      end
   end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
   import bar_win_pkg::*;
#(
   parameter int ADDR_W    = 56,
   parameter int REG_AW    = 8,
   parameter int REG_COUNT = 8192,
   parameter int INT_COUNT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   output logic              rewrite_err,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic [NUM_WIN-1:0] hit_vec,
   output logic [ADDR_W-1:0] hit_off
);
   localparam int SZ_W = ADDR_W + 1;
   localparam logic [SZ_W-1:0] RG_SIZE = SZ_W'(REG_COUNT) << 3;
   localparam logic [SZ_W-1:0] IN_SIZE = SZ_W'(INT_COUNT) << 16;

   generate
      if (ADDR_W > 64 - BASE_SHIFT || ADDR_W < 40) begin : g_bad_aw
         $error("ADDR_W must lie in 40..56");
      end
      if (REG_AW < 6) begin : g_bad_raw
         $error("REG_AW too small for the register map");
      end
      if (REG_COUNT < 1 || INT_COUNT < 1) begin : g_bad_cnt
         $error("window counts must be positive");
      end
   endgenerate

   logic [NUM_WIN-1:0][63:0]     base_q;
   logic [1:0][63:0]             mask_q;
   logic [NUM_WIN-1:0]           win_en;
   logic [NUM_WIN-1:0][ADDR_W-1:0] start;
   logic [NUM_WIN-1:0][SZ_W-1:0]   size;
   logic [NUM_WIN-1:0]             raw_hit;
   logic [NUM_WIN-1:0][ADDR_W-1:0] raw_off;

   bar_cfg_regs #(.REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rewrite_err(rewrite_err), .base_q(base_q), .mask_q(mask_q),
      .win_en(win_en)
   );

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         logic [63:0] base_sh;
         logic        unused_bits;
         assign base_sh  = base_q[w] >> BASE_SHIFT;
         assign start[w] = base_sh[ADDR_W-1:0];
         if (w == W_MMIO0 || w == W_MMIO1) begin : g_masked
            logic [63:0] inv_sh;
            assign inv_sh      = (~mask_q[w]) >> BASE_SHIFT;
            assign size[w]     = {1'b0, inv_sh[ADDR_W-1:0]} + SZ_W'(1);
            assign unused_bits = ^{base_sh, inv_sh};
         end else if (w == W_REGS) begin : g_regs
            assign size[w]     = RG_SIZE;
            assign unused_bits = ^base_sh;
         end else begin : g_intr
            assign size[w]     = IN_SIZE;
            assign unused_bits = ^base_sh;
         end
         bar_win_match #(.ADDR_W(ADDR_W)) u_match (
            .en(win_en[w]), .addr(lk_addr), .start(start[w]),
            .size(size[w]), .hit(raw_hit[w]), .off(raw_off[w])
         );
      end
   endgenerate

   bar_prio_sel #(.N(NUM_WIN), .ADDR_W(ADDR_W)) u_prio (
      .hit_in(raw_hit), .off_in(raw_off),
      .hit_out(hit_vec), .off_out(hit_off)
   );
endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk #(
   parameter int ADDR_W = 56,
   parameter int REG_AW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic [63:0]       reg_rdata,
   input logic              rewrite_err,
   input logic [3:0]        hit_vec,
   input logic [ADDR_W-1:0] hit_off,
   input logic [3:0]        win_en
);
   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R9
   AST_MISS_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec == 4'b0) |-> (hit_off == '0)); // R10
   AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rewrite_err |-> $past(reg_we)); // R11
   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec & ~win_en) == 4'b0); // R8
   AST_ENABLE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[REG_AW-1:3] == 6) |-> (reg_rdata[59:0] == '0)); // R3
   AST_MMIO_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[REG_AW-1:3] < 4) |-> (reg_rdata[23:0] == '0)); // R4
endmodule

bind bar_window_decoder bar_window_decoder_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .rewrite_err(rewrite_err), .hit_vec(hit_vec),
   .hit_off(hit_off), .win_en(win_en)
);

// File: tb/bar_window_decoder_test.sv
`timescale 1ns/1ps
module bar_window_decoder_test;
   localparam int AW = 56;
   localparam int NV = 10;
   // {address, expected hit, expected offset}
   localparam logic [AW+4+AW-1:0] VEC [NV] = '{
      {56'h1_0000_0000, 4'b0001, 56'h0},        // R6 first byte MMIO0
      {56'h1_000F_FFFF, 4'b0001, 56'hF_FFFF},   // R6 last byte MMIO0
      {56'h1_0010_0000, 4'b0000, 56'h0},        // R6 one past MMIO0
      {56'h0_FFFF_FFFF, 4'b0000, 56'h0},        // R6 below MMIO0
      {56'h2_0000_1234, 4'b0010, 56'h1234},     // R6 MMIO1 interior
      {56'h2_0001_0000, 4'b0000, 56'h0},        // R6 one past MMIO1
      {56'h3_0000_FFF8, 4'b0100, 56'hFFF8},     // R7 reg window end
      {56'h3_0001_0000, 4'b0000, 56'h0},        // R7 past reg window
      {56'h4_000F_FFFF, 4'b1000, 56'hF_FFFF},   // R7 int window end
      {56'h4_0010_0000, 4'b0000, 56'h0}         // R7 past int window
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [63:0]   reg_wdata = '0;
   logic [63:0]   reg_rdata;
   logic          rewrite_err;
   logic [AW-1:0] lk_addr = '0;
   logic [3:0]    hit_vec;
   logic [AW-1:0] hit_off;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   bar_window_decoder uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rewrite_err(rewrite_err),
      .lk_addr(lk_addr), .hit_vec(hit_vec), .hit_off(hit_off)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [63:0] exp);
      reg_addr = a; #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic look(input string req, input logic [AW-1:0] a,
                       input logic [3:0] eh, input logic [AW-1:0] eo);
      lk_addr = a; #1;
      chk({req, " hit"}, 64'(hit_vec), 64'(eh));
      chk({req, " off"}, 64'(hit_off), 64'(eo));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      for (int i = 0; i < 7; i++) rd("R1 reset reg", 8'(i * 8), 64'h0);
      look("R1 reset", 56'h0, 4'b0000, 56'h0);
      chk("R1 err", 64'(rewrite_err), 64'h0);
      // R3/R4/R5 truncation (all windows disabled)
      wr(8'h30, '1); rd("R3 enable keep", 8'h30, 64'hF000_0000_0000_0000);
      wr(8'h30, 64'h0);
      wr(8'h08, '1); rd("R4 mask keep", 8'h08, 64'hFFFF_FFFF_FF00_0000);
      chk("R11 no err disabled", 64'(rewrite_err), 64'h0);
      wr(8'h10, '1); rd("R4 base keep", 8'h10, 64'hFFFF_FFFF_FF00_0000);
      wr(8'h20, '1); rd("R5 reg base keep", 8'h20, 64'hFFFF_FFFF_FFC0_0000);
      wr(8'h28, '1); rd("R5 int base keep", 8'h28, 64'hFFFF_FFF0_0000_0000);
      // R2 unmapped index and low address bits
      wr(8'h38, '1); rd("R2 unmapped", 8'h38, 64'h0);
      rd("R2 unmapped no side effect", 8'h30, 64'h0);
      wr(8'h05, 64'h0000_0100_0000_0000);
      rd("R2 low bits ignored", 8'h00, 64'h0000_0100_0000_0000);
      // configure windows
      wr(8'h08, 64'hFFFF_FFFF_F000_0000);
      wr(8'h10, 64'h0000_0200_0000_0000);
      wr(8'h18, 64'hFFFF_FFFF_FF00_0000);
      wr(8'h20, 64'h0000_0300_0000_0000);
      wr(8'h28, 64'h0000_0400_0000_0000);
      look("R8 all disabled", 56'h1_0000_0000, 4'b0000, 56'h0);
      wr(8'h30, 64'hF000_0000_0000_0000);
      // table walk
      for (int v = 0; v < NV; v++)
         look($sformatf("R6/R7/R10 vec%0d", v), VEC[v][2*AW+3:AW+4],
              VEC[v][AW+3:AW], VEC[v][AW-1:0]);
      // R8 disable MMIO0 only
      wr(8'h30, 64'h7000_0000_0000_0000);
      look("R8 mmio0 off", 56'h1_0000_0040, 4'b0000, 56'h0);
      wr(8'h30, 64'hF000_0000_0000_0000);
      // R11 rewrite while enabled: error pulse, value taken
      wr(8'h10, 64'h0000_0100_0000_0000);
      chk("R11 err pulse", 64'(rewrite_err), 64'h1);
      rd("R11 write taken", 8'h10, 64'h0000_0100_0000_0000);
      @(posedge clk); #1;
      chk("R11 pulse ends", 64'(rewrite_err), 64'h0);
      wr(8'h28, 64'h0000_0400_0000_0000);
      chk("R11 int err", 64'(rewrite_err), 64'h1);
      // R9 overlap: MMIO1 now sits on MMIO0
      look("R9 overlap prio", 56'h1_0000_0010, 4'b0001, 56'h10);
      wr(8'h30, 64'h7000_0000_0000_0000);
      look("R9 mmio1 takes over", 56'h1_0000_0010, 4'b0010, 56'h10);
      look("R9 mmio1 size", 56'h1_0001_0000, 4'b0000, 56'h0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule